// File: doc/BRIEF.md
# Multichannel Sample Serializer with Training Patterns

This block turns a parallel bank of converter samples into one serial bit lane per channel. All timing comes from one fast clock that runs at twelve times the sample rate. Every twelve fast cycles each lane sends one 12-bit frame, one bit per cycle. With the data the block drives two reference clocks. One is a bit clock at six times the sample rate, with one data bit in each half period. The other is a frame clock at the sample rate that goes high on the first bit of every frame. The two clocks and the data lanes leave the same register stage, so they stay in phase.

A small write port selects the bit order and the source of each frame. The source can be live sample data, an alternating training stream, a half-zero/half-one framing stream, or a programmed 12-bit word. The same port can switch off single lanes. The sample inputs and the settings are copied into a per-lane holding register on the frame boundary. The frame on the wire therefore never mixes two samples or two settings. Reset forces every lane to zero while both reference clocks keep running.

Top module: `adc_lane_serializer`

## Requirements
- R1: Each lane sends a 12-bit frame over 12 consecutive fast cycles. Slot 0 of a frame is the first fast cycle in which the frame clock output is high. In normal-data mode (control field `cfg_wdata[2:1]` = 0 at address 0) with least-significant-first order, slot k carries bit k of that lane's sample (lane i takes `sample_in[12*i +: 12]`).
- R2: Writing 1 to `cfg_wdata[0]` at address 0 selects most-significant-first order: slot k carries bit 11-k.
- R3: The bit clock output is high in even slots and low in odd slots, so it toggles on every fast cycle.
- R4: The frame clock output is high in slots 0 to 5 and low in slots 6 to 11.
- R5: Source code 1 sends the training stream on every enabled lane: slot k is 1 when k is odd and 0 when k is even, whatever the bit order.
- R6: Source code 2 sends zeros in slots 0 to 5 and ones in slots 6 to 11 on every enabled lane, whatever the bit order.
- R7: Source code 3 sends the 12-bit word held at address 1 on every enabled lane, in the selected bit order.
- R8: While `rst` is high, every lane outputs 0 from the first clock edge in reset onward, and the bit and frame clocks keep toggling.
- R9: A 1 in bit i of the mask at address 2 holds lane i at the idle level 0 for the whole frame. Lanes whose mask bit is 0 are not affected.
- R10: Samples and settings are taken on the clock edge that emits slot 11 and govern the next frame. Changes at the inputs during a frame do not alter the frame being sent.
- R11: Reset restores least-significant-first order, normal data, custom word 0 and all lanes enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ser | input | 1 | Fast clock, twelve times the sample rate |
| rst | input | 1 | Synchronous active-high reset |
| sample_in | input | 96 | Eight 12-bit samples, lane i at bits 12*i+11..12*i |
| cfg_wr_en | input | 1 | Setting write strobe |
| cfg_addr | input | 2 | Setting address: 0 control, 1 custom word, 2 lane-off mask |
| cfg_wdata | input | 12 | Setting write data |
| lane_out | output | 8 | Serial data, one bit per lane |
| bit_clk_out | output | 1 | Bit clock at six times the sample rate |
| frame_clk_out | output | 1 | Frame clock at the sample rate |

## Verification
A slot counter that drifts shows up within one frame. The frame clock then loses its six-high, six-low shape, or the bit clock stops alternating. Every data bit after that lands in the wrong slot. A holding register that loads at the wrong time, or loads the wrong source, damages whole frames. The bench upsets `sample_in` in the middle of every frame, so a capture taken early or late puts the inverted word on the lanes in the very next frame. A setting register that resets wrong shows in the first frame sent after reset is released.

// File: rtl/ser_pkg.sv
package ser_pkg;

    localparam int unsigned FRAME_BITS = 12;
    localparam int unsigned LANE_COUNT = 8;

    // Setting addresses
    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_CUSTOM = 2'd1;
    localparam logic [1:0] ADDR_LANEOFF = 2'd2;

    typedef enum logic [1:0] {
        SRC_DATA   = 2'd0,
        SRC_DESKEW = 2'd1,
        SRC_SYNC   = 2'd2,
        SRC_CUSTOM = 2'd3
    } src_mode_e;

    typedef struct packed {
        logic      msb_first;
        src_mode_e mode;
    } ser_ctrl_t;

    localparam ser_ctrl_t CTRL_DEFAULT = '{msb_first: 1'b0, mode: SRC_DATA};

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/ser_slot_timer.sv
module ser_slot_timer #(
    parameter int unsigned SLOTS  = 12,
    parameter int unsigned SLOT_W = $clog2(SLOTS)
) (
    input  logic              clk,
    output logic [SLOT_W-1:0] slot_o,
    output logic              capture_o,
    output logic              bit_clk_o,
    output logic              frame_clk_o
);
    localparam logic [SLOT_W-1:0] LAST = SLOT_W'(SLOTS - 1);
    localparam logic [SLOT_W-1:0] HALF = SLOT_W'(SLOTS / 2);

    logic [SLOT_W-1:0] slot_q;
    logic              bit_clk_q;
    logic              frame_q;
    logic              armed_q;

    // Free-running: the reference clocks must keep running through reset.
    // Any out-of-range count wraps to zero on the next edge.
    always_ff @(posedge clk) begin
        slot_q    <= (slot_q >= LAST) ? '0 : slot_q + 1'b1;
        bit_clk_q <= ~slot_q[0];
        frame_q   <= (slot_q < HALF);
        armed_q   <= 1'b1;
    end

    assign slot_o      = slot_q;
    assign capture_o   = (slot_q == LAST);
    assign bit_clk_o   = bit_clk_q;
    assign frame_clk_o = frame_q;

    // R3
    bit_clk_toggle_hi_chk: assert property (@(posedge clk) disable iff (!armed_q)
        bit_clk_q |=> !bit_clk_q);
    // R3
    bit_clk_toggle_lo_chk: assert property (@(posedge clk) disable iff (!armed_q)
        !bit_clk_q |=> bit_clk_q);
    // R4
    frame_rise_align_chk: assert property (@(posedge clk) disable iff (!armed_q)
        $rose(frame_q) |-> bit_clk_q);
    // R4
    frame_fall_align_chk: assert property (@(posedge clk) disable iff (!armed_q)
        $fell(frame_q) |-> bit_clk_q);

endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
    import ser_pkg::*;
#(
    parameter int unsigned LANES = 8,
    parameter int unsigned WORD  = 12,
    parameter int unsigned CFG_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [1:0]       addr,
    input  logic [CFG_W-1:0] wdata,
    output ser_ctrl_t        ctrl_o,
    output logic [WORD-1:0]  custom_o,
    output logic [LANES-1:0] laneoff_o
);
    ser_ctrl_t        ctrl_q;
    logic [WORD-1:0]  custom_q;
    logic [LANES-1:0] laneoff_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= CTRL_DEFAULT;
            custom_q  <= '0;
            laneoff_q <= '0;
        end else if (wr_en) begin
            unique case (addr)
                ADDR_CTRL: begin
                    ctrl_q.msb_first <= wdata[0];
                    ctrl_q.mode      <= src_mode_e'(wdata[2:1]);
                end
                ADDR_CUSTOM:  custom_q  <= wdata[WORD-1:0];
                ADDR_LANEOFF: laneoff_q <= wdata[LANES-1:0];
                default: ;
            endcase
        end
    end

    assign ctrl_o    = ctrl_q;
    assign custom_o  = custom_q;
    assign laneoff_o = laneoff_q;

    // R11
    cfg_reset_default_chk: assert property (@(posedge clk)
        rst |=> (ctrl_q == CTRL_DEFAULT) && (laneoff_q == '0));

endmodule

// File: rtl/ser_lane.sv
module ser_lane
    import ser_pkg::*;
#(
    parameter int unsigned W      = 12,
    parameter bit          IDLE   = 1'b0,
    parameter int unsigned SLOT_W = $clog2(W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              capture_i,
    input  logic [SLOT_W-1:0] slot_i,
    input  ser_ctrl_t         ctrl_i,
    input  logic [W-1:0]      custom_i,
    input  logic              off_i,
    input  logic [W-1:0]      sample_i,
    output logic              lane_o
);
    logic [W-1:0] word_nx;   // indexed by slot
    logic [W-1:0] word_q;
    logic         off_q;
    logic         lane_q;

    always_comb begin
        for (int k = 0; k < W; k++) begin
            unique case (ctrl_i.mode)
                SRC_DESKEW: word_nx[k] = k[0];
                SRC_SYNC:   word_nx[k] = (k >= int'(W / 2));
                SRC_CUSTOM: word_nx[k] = ctrl_i.msb_first ? custom_i[W-1-k] : custom_i[k];
                default:    word_nx[k] = ctrl_i.msb_first ? sample_i[W-1-k] : sample_i[k];
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            word_q <= '0;
            off_q  <= 1'b0;
            lane_q <= 1'b0;
        end else begin
            if (capture_i) begin
                word_q <= word_nx;
                off_q  <= off_i;
            end
            lane_q <= off_q ? IDLE : word_q[slot_i];
        end
    end

    assign lane_o = lane_q;

    // R8
    lane_reset_zero_chk: assert property (@(posedge clk)
        rst |=> !lane_q);
    // R9
    lane_off_idle_chk: assert property (@(posedge clk) disable iff (rst)
        off_q |=> (lane_q == IDLE));
    // R10
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !capture_i |=> $stable(word_q) && $stable(off_q));

endmodule

// File: rtl/adc_lane_serializer.sv
module adc_lane_serializer
    import ser_pkg::*;
#(
    parameter int unsigned LANES    = LANE_COUNT,
    parameter int unsigned SAMPLE_W = FRAME_BITS,
    parameter bit          OFF_IDLE = 1'b0,
    parameter int unsigned CFG_W    = max2(SAMPLE_W, LANES)
) (
    input  logic                      clk_ser,
    input  logic                      rst,
    input  logic [LANES*SAMPLE_W-1:0] sample_in,
    input  logic                      cfg_wr_en,
    input  logic [1:0]                cfg_addr,
    input  logic [CFG_W-1:0]          cfg_wdata,
    output logic [LANES-1:0]          lane_out,
    output logic                      bit_clk_out,
    output logic                      frame_clk_out
);
    localparam int unsigned SLOT_W = $clog2(SAMPLE_W);

    logic [SLOT_W-1:0] slot;
    logic              capture;
    ser_ctrl_t         ctrl;
    logic [SAMPLE_W-1:0] custom;
    logic [LANES-1:0]  laneoff;

    ser_slot_timer #(
        .SLOTS  (SAMPLE_W),
        .SLOT_W (SLOT_W)
    ) u_timer (
        .clk         (clk_ser),
        .slot_o      (slot),
        .capture_o   (capture),
        .bit_clk_o   (bit_clk_out),
        .frame_clk_o (frame_clk_out)
    );

    ser_cfg_regs #(
        .LANES (LANES),
        .WORD  (SAMPLE_W),
        .CFG_W (CFG_W)
    ) u_cfg (
        .clk       (clk_ser),
        .rst       (rst),
        .wr_en     (cfg_wr_en),
        .addr      (cfg_addr),
        .wdata     (cfg_wdata),
        .ctrl_o    (ctrl),
        .custom_o  (custom),
        .laneoff_o (laneoff)
    );

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        ser_lane #(
            .W      (SAMPLE_W),
            .IDLE   (OFF_IDLE),
            .SLOT_W (SLOT_W)
        ) u_lane (
            .clk       (clk_ser),
            .rst       (rst),
            .capture_i (capture),
            .slot_i    (slot),
            .ctrl_i    (ctrl),
            .custom_i  (custom),
            .off_i     (laneoff[i]),
            .sample_i  (sample_in[i*SAMPLE_W +: SAMPLE_W]),
            .lane_o    (lane_out[i])
        );
    end

endmodule

// File: tb/adc_lane_serializer_tb.sv
module adc_lane_serializer_tb;
    localparam int CLK_PERIOD = 10;
    localparam int LANES = 8;
    localparam int W = 12;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic [LANES*W-1:0] sample_in = '0;
    logic               cfg_wr_en = 1'b0;
    logic [1:0]         cfg_addr = '0;
    logic [11:0]        cfg_wdata = '0;
    logic [LANES-1:0]   lane_out;
    logic               bit_clk_out;
    logic               frame_clk_out;

    int n_checks = 0;
    int n_fails  = 0;

    // bench model of the settings
    logic        m_msb;
    logic [1:0]  m_mode;
    logic [11:0] m_custom;
    logic [7:0]  m_off;

    logic [11:0] exp_w [LANES];
    string       exp_tag [LANES];
    bit          exp_valid = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_lane_serializer u_dut (
        .clk_ser       (clk),
        .rst           (rst),
        .sample_in     (sample_in),
        .cfg_wr_en     (cfg_wr_en),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .lane_out      (lane_out),
        .bit_clk_out   (bit_clk_out),
        .frame_clk_out (frame_clk_out)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // slot-indexed expected frame word
    function automatic logic [11:0] exp_word(input logic [11:0] smp, input logic [1:0] mode,
                                             input logic msb, input logic [11:0] cust);
        logic [11:0] src, r;
        if (mode == 2'd1) return 12'hAAA;
        if (mode == 2'd2) return 12'hFC0;
        src = (mode == 2'd3) ? cust : smp;
        for (int k = 0; k < 12; k++) r[k] = msb ? src[11-k] : src[k];
        return r;
    endfunction

    function automatic string mode_tag(input logic [1:0] mode, input logic msb);
        case (mode)
            2'd1: return "R5";
            2'd2: return "R6";
            2'd3: return "R7";
            default: return msb ? "R2" : "R1";
        endcase
    endfunction

    task automatic model_defaults();
        m_msb = 1'b0; m_mode = 2'd0; m_custom = '0; m_off = '0;
        exp_valid = 1'b0;
    endtask

    task automatic sync_frame();
        logic p;
        bit   found;
        found = 1'b0;
        p = frame_clk_out;
        while (!found) begin
            @(negedge clk);
            if (!p && frame_clk_out) found = 1'b1;
            p = frame_clk_out;
        end
    endtask

    // Entered at the negedge that shows slot 0; leaves at the next slot 0.
    task automatic run_frame(input bit do_wr, input logic msb, input logic [1:0] mode,
                             input logic [11:0] cust, input logic [7:0] off,
                             input logic [LANES*W-1:0] smp, input string tag);
        logic [11:0] got [LANES];
        logic [11:0] bc, fc;
        for (int s = 0; s < 12; s++) begin
            if (s > 0) @(negedge clk);
            for (int l = 0; l < LANES; l++) got[l][s] = lane_out[l];
            bc[s] = bit_clk_out;
            fc[s] = frame_clk_out;
            case (s)
                0: begin
                    sample_in = smp;
                    cfg_wr_en = do_wr; cfg_addr = 2'd0;
                    cfg_wdata = {9'd0, mode, msb};
                end
                1: begin cfg_addr = 2'd1; cfg_wdata = cust; end
                2: begin cfg_addr = 2'd2; cfg_wdata = {4'd0, off}; end
                3: cfg_wr_en = 1'b0;
                6: sample_in = ~smp;   // R10: mid-frame disturbance
                9: sample_in = smp;
                default: ;
            endcase
        end
        @(negedge clk);
        // R3 / R4 clock shapes within the frame
        check(bc == 12'h555, "R3", "bit clock per slot", bc, 12'h555);
        check(fc == 12'h03F, "R4", "frame clock per slot", fc, 12'h03F);
        if (exp_valid)
            for (int l = 0; l < LANES; l++)
                check(got[l] == exp_w[l], exp_tag[l], $sformatf("lane %0d frame", l),
                      got[l], exp_w[l]);
        if (do_wr) begin
            m_msb = msb; m_mode = mode; m_custom = cust; m_off = off;
        end
        for (int l = 0; l < LANES; l++) begin
            if (m_off[l]) begin
                exp_w[l] = 12'h000;
                exp_tag[l] = "R9";
            end else begin
                exp_w[l] = exp_word(smp[l*W +: W], m_mode, m_msb, m_custom);
                exp_tag[l] = (tag != "") ? tag : mode_tag(m_mode, m_msb);
            end
        end
        exp_valid = 1'b1;
    endtask

    task automatic reset_phase(input int cycles);
        logic p;
        int   rises;
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rises = 0;
        for (int c = 0; c < cycles; c++) begin
            p = bit_clk_out;
            if (c > 0) begin
                check(lane_out == '0, "R8", "lanes in reset", lane_out, 0);
            end
            @(negedge clk);
            check(bit_clk_out != p, "R8", "bit clock runs in reset", bit_clk_out, !p);
            if (frame_clk_out && !p && bc_frame_rise(frame_clk_out)) rises++;
        end
        check(lane_out == '0, "R8", "lanes at end of reset", lane_out, 0);
        rst = 1'b0;
        model_defaults();
        sync_frame();
    endtask

    logic fc_prev = 1'b0;
    function automatic bit bc_frame_rise(input logic fc_now);
        bit r;
        r = fc_now && !fc_prev;
        fc_prev = fc_now;
        return r;
    endfunction

    function automatic logic [LANES*W-1:0] rnd_samples();
        logic [LANES*W-1:0] v;
        for (int l = 0; l < LANES; l++) v[l*W +: W] = 12'($urandom);
        return v;
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [LANES*W-1:0] pat;
        int unsigned seed;
        seed = $urandom(32'd20240917);
        model_defaults();
        repeat (3) @(negedge clk);
        reset_phase(30);

        // R11: first frames after reset use defaults without any write
        pat = {12'h801, 12'h123, 12'h456, 12'h789, 12'hABC, 12'hDEF, 12'h000, 12'hFFF};
        run_frame(1'b0, 1'b0, 2'd0, 12'h0, 8'h00, pat, "R11");
        run_frame(1'b0, 1'b0, 2'd0, 12'h0, 8'h00, pat, "R11");
        // directed modes
        run_frame(1'b1, 1'b0, 2'd0, 12'h000, 8'h00, {8{12'hABC}}, "R1");
        run_frame(1'b1, 1'b1, 2'd0, 12'h000, 8'h00, {8{12'hABC}}, "R2");
        run_frame(1'b1, 1'b1, 2'd0, 12'h000, 8'h00, pat, "R2");
        run_frame(1'b1, 1'b0, 2'd1, 12'h000, 8'h00, pat, "R5");
        run_frame(1'b1, 1'b1, 2'd2, 12'h000, 8'h00, pat, "R6");
        run_frame(1'b1, 1'b0, 2'd3, 12'h5A3, 8'h00, pat, "R7");
        run_frame(1'b1, 1'b1, 2'd3, 12'h5A3, 8'h00, pat, "R7");
        run_frame(1'b1, 1'b0, 2'd0, 12'h000, 8'hA5, {8{12'hFFF}}, "");
        run_frame(1'b1, 1'b0, 2'd0, 12'h000, 8'hFF, {8{12'hFFF}}, "");
        run_frame(1'b1, 1'b0, 2'd0, 12'h000, 8'h00, {8{12'hFFF}}, "R10");
        run_frame(1'b1, 1'b1, 2'd0, 12'h000, 8'h00, {8{12'h001}}, "R10");

        // constrained random frames
        for (int f = 0; f < 60; f++) begin
            logic [1:0] md;
            logic [7:0] off;
            md  = 2'($urandom);
            off = (($urandom % 4) == 0) ? 8'($urandom) : 8'h00;
            run_frame(($urandom % 5) != 0, 1'($urandom), md, 12'($urandom), off,
                      rnd_samples(), "");
        end

        // leave non-default settings, then reset in mid-run
        run_frame(1'b1, 1'b1, 2'd3, 12'h9C1, 8'h0F, rnd_samples(), "");
        repeat (5) @(negedge clk);
        reset_phase(40);
        run_frame(1'b0, 1'b1, 2'd3, 12'h9C1, 8'h0F, pat, "R11");
        run_frame(1'b0, 1'b1, 2'd3, 12'h9C1, 8'h0F, rnd_samples(), "R11");
        run_frame(1'b0, 1'b0, 2'd0, 12'h000, 8'h00, pat, "R11");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule